// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is a single 16-bit channel that sits beside a free-running timer. A mode bit in a small control register sets what the channel does. In capture mode it watches an external trigger pin. When the selected edge appears on that pin, it stores the current timer count and pulses a capture interrupt. In compare mode it holds a value written by software. It checks that value against the timer count on every cycle and pulses a match interrupt when the two become equal.

Software reaches the channel through a simple register bus with a one-bit address. Address 0 holds the 16-bit capture/compare value. Address 1 is the control word, whose bit 0 is the mode. Writes to the value are gated by the mode and by the timer-enable input. Read data comes back through a holding register. Because of that register, two back-to-back reads of the same address return the held copy and not the live contents. Software must read the other address between two reads of one address. The trigger pin is asynchronous, so the channel synchronises it before looking for an edge.

Top module: `tmr_capcmp_chan`

## Requirements
- R1: After reset the value register is 0x0000, the mode is capture (0), and both interrupt outputs are low.
- R2: A read of address 1 returns the mode in bit 0 and zeros in bits 15:1. A write to address 1 loads the mode from bit 0 of the write data, where 0 means capture and 1 means compare.
- R3: While the mode is capture, a bus write to address 0 leaves the value register unchanged.
- R4: While the mode is compare, a bus write to address 0 is accepted when `tmr_run` is 0 and ignored when `tmr_run` is 1.
- R5: While `tmr_run` is 0, trigger edges cause neither a capture nor a capture interrupt.
- R6: `trig_sel` chooses the valid trigger edge: 00 means none, 01 means rising, 10 means falling, and 11 means both edges.
- R7: On a valid edge in capture mode with `tmr_run` at 1, the channel latches `tmr_count` as sampled at the third rising clock edge after the pin changes. At the same edge `cap_irq` goes high for exactly one cycle.
- R8: In compare mode, `cmp_irq` goes high for one cycle in the cycle after the first cycle in which `tmr_count` equals the value. It does not pulse again while the equality persists.
- R9: A read request at address A produces `bus_rvalid` one cycle later. `bus_rdata` is refreshed from address A only if the previous read was of a different address or no read has occurred since reset. Otherwise it returns the held data.
- R10: Changing the mode does not alter the value register.
- R11: A captured value is held unchanged until the next valid capture replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_req | input | 1 | Bus access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = value register, 1 = control word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data from the holding register |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| tmr_count | input | 16 | Current count of the attached timer |
| tmr_run | input | 1 | Timer enable |
| trig_pin | input | 1 | Asynchronous external capture trigger |
| trig_sel | input | 2 | Valid-edge select (00 none, 01 rise, 10 fall, 11 both) |
| cap_irq | output | 1 | One-cycle capture interrupt |
| cmp_irq | output | 1 | One-cycle compare-match interrupt |

## Verification
A corrupted value register appears at the ports in two ways. The next read of address 0 after a read of address 1 shows it, and in compare mode it also moves or removes the `cmp_irq` pulse on the cycle the timer reaches the expected value. A fault in the synchroniser or edge history shifts or drops a `cap_irq` pulse, which shows within three clocks of the pin change. A stuck match history shows as a missing or repeated pulse on the very next cycle of equality. Errors in the read-hold state appear on the first read after the faulty update, as data that is stale when it should be fresh or fresh when it should be stale.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  localparam int ADDR_W = 1;
  localparam logic [ADDR_W-1:0] ADDR_VAL = 1'b0;
  localparam logic [ADDR_W-1:0] ADDR_CTL = 1'b1;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam int MODE_BIT = 0;
endpackage

// File: rtl/trig_edge_det.sv
module trig_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic [1:0] sel_i,
  output logic       hit_o
);
  import capcmp_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;
  logic                   lvl;
  logic                   rise, fall;
  edge_sel_e              sel;

  assign lvl = sync_q[SYNC_STAGES-1];

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb sync_d = pin_i;
    end else begin : g_many
      always_comb sync_d = {sync_q[SYNC_STAGES-2:0], pin_i};
    end
  endgenerate

  always_comb begin
    prev_d = lvl;
    sel    = edge_sel_e'(sel_i);
    rise   = lvl & ~prev_q;
    fall   = ~lvl & prev_q;
    unique case (sel)
      EDGE_RISE: hit_o = rise;
      EDGE_FALL: hit_o = fall;
      EDGE_BOTH: hit_o = rise | fall;
      default:   hit_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end
endmodule

// File: rtl/capcmp_match.sv
module capcmp_match #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active_i,
  input  logic [W-1:0] ref_i,
  input  logic [W-1:0] cnt_i,
  output logic         irq_o
);
  logic eq;
  logic eq_q, eq_d;
  logic irq_q, irq_d;

  always_comb begin
    eq    = active_i && (ref_i == cnt_i);
    eq_d  = eq;
    irq_d = eq && !eq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eq_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      eq_q  <= eq_d;
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/capcmp_rdhold.sv
module capcmp_rdhold #(
  parameter int W  = 16,
  parameter int AW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic [W-1:0]  live_i,
  output logic [W-1:0]  rd_data_o,
  output logic          rd_valid_o
);
  logic [W-1:0]  hold_q, hold_d;
  logic [AW-1:0] last_q, last_d;
  logic          seen_q, seen_d;
  logic          vld_q, vld_d;
  logic          refresh;

  always_comb begin
    refresh = rd_req_i && (!seen_q || (rd_addr_i != last_q));
    hold_d  = hold_q;
    last_d  = last_q;
    seen_d  = seen_q;
    vld_d   = rd_req_i;
    if (refresh) begin
      hold_d = live_i;
      last_d = rd_addr_i;
      seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      last_q <= '0;
      seen_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (refresh) begin
        hold_q <= hold_d;
        last_q <= last_d;
        seen_q <= seen_d;
      end
    end
  end

  assign rd_data_o  = hold_q;
  assign rd_valid_o = vld_q;
endmodule

// File: rtl/tmr_capcmp_chan.sv
module tmr_capcmp_chan #(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_req,
  input  logic                           bus_wr,
  input  logic [capcmp_pkg::ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  output logic [DATA_W-1:0]              bus_rdata,
  output logic                           bus_rvalid,
  input  logic [DATA_W-1:0]              tmr_count,
  input  logic                           tmr_run,
  input  logic                           trig_pin,
  input  logic [1:0]                     trig_sel,
  output logic                           cap_irq,
  output logic                           cmp_irq
);
  import capcmp_pkg::*;

  localparam int PAD_W = DATA_W - 1;

  // reset: asserted asynchronously, released on the clock
  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[RST_STAGES-1];

  logic              mode_q, mode_d, mode_en;
  logic [DATA_W-1:0] val_q, val_d;
  logic              val_en;
  logic              cap_q, cap_d;
  logic              trig_hit;
  logic              cap_fire;
  logic              wr_val_ok;
  logic              rd_req;
  logic [DATA_W-1:0] live_word;
  logic [DATA_W-1:0] ctl_word;

  trig_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .rst_n (rst_int_n),
    .pin_i (trig_pin),
    .sel_i (trig_sel),
    .hit_o (trig_hit)
  );

  capcmp_match #(.W(DATA_W)) u_match (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .active_i (mode_q),
    .ref_i    (val_q),
    .cnt_i    (tmr_count),
    .irq_o    (cmp_irq)
  );

  always_comb begin
    cap_fire  = !mode_q && tmr_run && trig_hit;
    wr_val_ok = bus_req && bus_wr && (bus_addr == ADDR_VAL) && mode_q && !tmr_run;
    mode_en   = bus_req && bus_wr && (bus_addr == ADDR_CTL);
    mode_d    = bus_wdata[MODE_BIT];
    val_en    = cap_fire || wr_val_ok;
    val_d     = cap_fire ? tmr_count : bus_wdata;
    cap_d     = cap_fire;
    rd_req    = bus_req && !bus_wr;
    ctl_word  = {{PAD_W{1'b0}}, mode_q};
    live_word = (bus_addr == ADDR_VAL) ? val_q : ctl_word;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mode_q <= 1'b0;
      val_q  <= '0;
      cap_q  <= 1'b0;
    end else begin
      cap_q <= cap_d;
      if (mode_en) mode_q <= mode_d;
      if (val_en)  val_q  <= val_d;
    end
  end

  assign cap_irq = cap_q;

  capcmp_rdhold #(.W(DATA_W), .AW(ADDR_W)) u_rdhold (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .rd_req_i   (rd_req),
    .rd_addr_i  (bus_addr),
    .live_i     (live_word),
    .rd_data_o  (bus_rdata),
    .rd_valid_o (bus_rvalid)
  );
endmodule

// File: rtl/capcmp_chk.sv
module capcmp_chk #(
  parameter int DATA_W = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          bus_req,
  input logic                          bus_wr,
  input logic [capcmp_pkg::ADDR_W-1:0] bus_addr,
  input logic                          bus_rvalid,
  input logic [DATA_W-1:0]             tmr_count,
  input logic                          tmr_run,
  input logic                          cap_irq,
  input logic                          cmp_irq,
  input logic                          mode_q,
  input logic [DATA_W-1:0]             val_q
);
  import capcmp_pkg::*;

  // R3
  cap_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wr && bus_addr == ADDR_VAL && !mode_q && !tmr_run) |=> $stable(val_q));

  // R4
  cmp_wr_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wr && bus_addr == ADDR_VAL && mode_q && tmr_run) |=> $stable(val_q));

  // R5
  stopped_no_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_run |=> !cap_irq);

  // R7
  cap_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_irq |-> (val_q == $past(tmr_count)));

  // R7
  irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cap_irq, cmp_irq}));

  // R8
  cmp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_irq |=> !cmp_irq);

  // R8
  cmp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_irq |-> $past(mode_q && (tmr_count == val_q)));

  // R9
  rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_req && !bus_wr));

  // R10
  mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mode_q) && !cap_irq) |-> $stable(val_q));
endmodule

bind tmr_capcmp_chan capcmp_chk #(.DATA_W(DATA_W)) u_capcmp_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_rvalid (bus_rvalid),
  .tmr_count  (tmr_count),
  .tmr_run    (tmr_run),
  .cap_irq    (cap_irq),
  .cmp_irq    (cmp_irq),
  .mode_q     (mode_q),
  .val_q      (val_q)
);

// File: tb/test_tmr_capcmp_chan.sv
module test_tmr_capcmp_chan;
  logic        clk;
  logic        rst_n;
  logic        bus_req, bus_wr;
  logic [0:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        bus_rvalid;
  logic [15:0] tmr;
  logic        en, pin;
  logic [1:0]  esel;
  logic        cap_irq, cmp_irq;

  tmr_capcmp_chan i_tmr_capcmp_chan (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .tmr_count(tmr), .tmr_run(en),
    .trig_pin(pin), .trig_sel(esel), .cap_irq(cap_irq), .cmp_irq(cmp_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  int cap_seen = 0;
  int cmp_seen = 0;
  logic [15:0] last_rd;

  // bench model state
  logic [15:0] m_val;
  logic        m_mode, m_lasteq, m_lv, m_la;
  logic [15:0] m_held;
  logic        q1, q2, q3;

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model_live(input logic a);
    return (a == 1'b0) ? m_val : {15'b0, m_mode};
  endfunction

  // one clock cycle: drive bus, update the model, check outputs at the negedge
  task automatic cyc(input logic req, input logic wr, input logic a,
                     input logic [15:0] wd, input string tag);
    logic hit, cap, eq, cmp, rd;
    bus_req = req; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    hit = (esel[0] && q2 && !q3) || (esel[1] && !q2 && q3);
    cap = !m_mode && en && hit;
    eq  = m_mode && (tmr == m_val);
    cmp = eq && !m_lasteq;
    m_lasteq = eq;
    rd = req && !wr;
    if (rd && (!m_lv || a != m_la)) begin
      m_held = model_live(a); m_la = a; m_lv = 1'b1;
    end
    if (cap) m_val = tmr;
    else if (req && wr && a == 1'b0 && m_mode && !en) m_val = wd;
    if (req && wr && a == 1'b1) m_mode = wd[0];
    q3 = q2; q2 = q1; q1 = pin;
    @(posedge clk);
    @(negedge clk);
    chk({15'b0, cap_irq}, {15'b0, cap}, "R7 cap_irq timing");
    chk({15'b0, cmp_irq}, {15'b0, cmp}, "R8 cmp_irq timing");
    chk({15'b0, bus_rvalid}, {15'b0, rd}, "R9 rvalid");
    if (rd) chk(bus_rdata, m_held, tag);
    if (cap_irq) cap_seen++;
    if (cmp_irq) cmp_seen++;
    last_rd = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 16'h0, "idle");
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    cyc(1'b1, 1'b1, a, d, "write");
  endtask

  task automatic rd_fresh(input logic a, input string tag, output logic [15:0] d);
    cyc(1'b1, 1'b0, ~a, 16'h0, tag);
    cyc(1'b1, 1'b0, a, 16'h0, tag);
    d = last_rd;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [15:0] d;
    int c0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_req = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    tmr = 0; en = 0; pin = 0; esel = 2'b00;
    m_val = 0; m_mode = 0; m_lasteq = 0; m_lv = 0; m_la = 0; m_held = 0;
    q1 = 0; q2 = 0; q3 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk({14'b0, cap_irq, cmp_irq}, 16'h0, "R1 irqs after reset");
    cyc(1'b1, 1'b0, 1'b0, 16'h0, "R1 value after reset");
    chk(last_rd, 16'h0000, "R1 value after reset");
    cyc(1'b1, 1'b0, 1'b1, 16'h0, "R2 mode after reset");
    chk(last_rd, 16'h0000, "R1 mode after reset");

    // R3 capture mode rejects writes
    wr(1'b0, 16'h1234);
    rd_fresh(1'b0, "R3 write in capture mode", d);
    chk(d, 16'h0000, "R3 write in capture mode");

    // R7 exact capture cycle
    en = 1; esel = 2'b01;
    pin = 1; tmr = 16'h0100; cyc(0, 0, 0, 0, "R7");
    tmr = 16'h0101; cyc(0, 0, 0, 0, "R7");
    c0 = cap_seen;
    tmr = 16'h0102; cyc(0, 0, 0, 0, "R7");
    chk(16'(cap_seen - c0), 16'd1, "R7 capture pulse on third edge");
    tmr = 16'h0103; idle(20);
    rd_fresh(1'b0, "R7 captured count", d);
    chk(d, 16'h0102, "R7 captured count");
    // R11 held after idle time
    idle(30);
    rd_fresh(1'b0, "R11 value held", d);
    chk(d, 16'h0102, "R11 value held");

    // R5 stopped timer ignores triggers
    en = 0; c0 = cap_seen;
    pin = 0; idle(4); pin = 1; idle(4);
    chk(16'(cap_seen - c0), 16'd0, "R5 no capture while stopped");
    rd_fresh(1'b0, "R5 value unchanged", d);
    chk(d, 16'h0102, "R5 value unchanged");
    en = 1; pin = 0; idle(4);

    // R6 edge select sweep
    for (int s = 0; s < 4; s++) begin
      esel = 2'(s); c0 = cap_seen;
      tmr = 16'(16'h0200 + s);
      pin = 1; idle(4); pin = 0; idle(4);
      chk(16'(cap_seen - c0), (s == 0) ? 16'd0 : (s == 3) ? 16'd2 : 16'd1,
          "R6 edge select count");
    end
    rd_fresh(1'b0, "R6 last capture", d);
    chk(d, 16'h0203, "R6 last capture");

    // R10 and R2 mode change keeps value
    wr(1'b1, 16'h0001);
    rd_fresh(1'b1, "R2 mode readback", d);
    chk(d, 16'h0001, "R2 mode readback");
    rd_fresh(1'b0, "R10 value kept", d);
    chk(d, 16'h0203, "R10 value kept");

    // R4 compare write gating
    wr(1'b0, 16'h0555);
    rd_fresh(1'b0, "R4 write while running", d);
    chk(d, 16'h0203, "R4 write rejected while running");
    en = 0;
    wr(1'b0, 16'h0040);
    rd_fresh(1'b0, "R4 write while stopped", d);
    chk(d, 16'h0040, "R4 write accepted while stopped");

    // R9 stale back-to-back read
    wr(1'b0, 16'h0077);
    cyc(1'b1, 1'b0, 1'b0, 16'h0, "R9 stale read");
    chk(last_rd, 16'h0040, "R9 stale read returns held");
    cyc(1'b1, 1'b0, 1'b1, 16'h0, "R9 other address");
    cyc(1'b1, 1'b0, 1'b0, 16'h0, "R9 refreshed read");
    chk(last_rd, 16'h0077, "R9 refreshed after other address");
    wr(1'b0, 16'h0040);

    // R8 single match pulse
    en = 1; c0 = cmp_seen;
    tmr = 16'h003E; cyc(0, 0, 0, 0, "R8");
    tmr = 16'h003F; cyc(0, 0, 0, 0, "R8");
    tmr = 16'h0040; cyc(0, 0, 0, 0, "R8");
    cyc(0, 0, 0, 0, "R8"); cyc(0, 0, 0, 0, "R8");
    tmr = 16'h0041; cyc(0, 0, 0, 0, "R8");
    tmr = 16'h0040; cyc(0, 0, 0, 0, "R8");
    chk(16'(cmp_seen - c0), 16'd2, "R8 match pulses");

    // constrained random phase, all checked by the cycle model
    tmr = 0;
    for (int i = 0; i < 4000; i++) begin
      logic req, w, a;
      logic [15:0] wd;
      if ($urandom_range(3) == 0) pin = ~pin;
      en = ($urandom_range(7) != 0);
      if ($urandom_range(31) == 0) esel = 2'($urandom_range(3));
      if ($urandom_range(3) != 0) tmr = (tmr + 16'd1) & 16'h000F;
      req = ($urandom_range(5) == 0);
      w = $urandom_range(1) == 1;
      a = $urandom_range(1) == 1;
      wd = 16'($urandom_range(15));
      cyc(req, w, a, wd, w ? "write" : "R9 random read");
    end

    report();
    $finish;
  end
endmodule